// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is the slave end of a two-wire control bus: the master supplies a clock that is only ever an input here, and a single data line that changes direction during reads. No select line exists. Framing comes entirely from counting bits. A 13-bit access carries a 4-bit address, a direction bit and an 8-bit data byte. A separate reset pattern, a run of ones followed by two zeros, returns every control field to its power-on value.

Both bus wires are oversampled by a fast system clock. Each wire passes through a two-stage synchronizer, and a data bit is taken on every detected rising edge of the bus clock. Three control registers are held. The first is an 8-bit video gain code. The second packs a 5-bit black level, a gain-boost select and a 2-bit test-pad mode. The third holds an audio AGC enable. All decoded fields are driven straight out to the analog blocks they steer.

Top module: `twsl_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, `gain_code` is 0x00, `black_code` is 16, `boost_sel` is 0, `test_mode` is 00, `agc_en` is 0 and `sdata_oe` is 0.
- R2: An access is 13 bits, each taken on a rising edge of `sclk`. Address bits 3 down to 0 come first, then a direction bit (0 = write, 1 = read), then data bits 7 down to 0. A write to address 0 places the data byte on `gain_code` within a few system cycles of the 13th edge.
- R3: A write to address 1 sets `black_code` from data bits [4:0], `boost_sel` from bit 5 and `test_mode` from bits [7:6]. Mode codes are: 00 for pad off, 10 for gain-stage output test and 11 for converter input test.
- R4: A write to address 2 sets `agc_en` from data bit 0. A read of address 2 returns 0000000 followed by the enable bit.
- R5: On a read, `sdata_oe` rises in the system cycle after the edge that carries the direction bit. The register value is then presented MSB first, so that each of the next 8 rising edges of `sclk` finds one bit on `sdata_out`. `sdata_oe` falls after the 13th edge. Whenever `sdata_oe` is 0, `sdata_out` is 0.
- R6: Writes to addresses 3 to 15 change no output, and reads of those addresses return 0x00.
- R7: Sixteen consecutive ones on the data line, wherever they fall relative to access framing, followed by two zeros, restore all fields to their R1 values. Line drive stops as soon as the sixteenth one is taken.
- R8: A pattern may follow the previous one with no idle time. An access that starts on the very next edge after a reset pattern or after another access is decoded normally.
- R9: Ones beyond the sixteenth keep the slave waiting for the two terminating zeros. Access framing restarts only after those zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Bus clock from the master |
| sdata_in | input | 1 | Data line as seen at the pad input |
| sdata_out | output | 1 | Read data driven toward the pad |
| sdata_oe | output | 1 | Pad output enable, high while read data is driven |
| gain_code | output | 8 | Video gain code |
| black_code | output | 5 | Black level code |
| boost_sel | output | 1 | Extra video gain select |
| test_mode | output | 2 | Test pad mode |
| agc_en | output | 1 | Audio AGC enable |

## Verification
A bit counter that slips by one position shows at the ports on the next access. Addresses and data then decode shifted, so the register fields take wrong values within 13 bus clocks, and a read either drives the wrong bits or turns the line around one edge early or late. A ones counter or reset-hunt state that goes wrong shows in one of two ways: fields fall back to power-on values when they should not, or a later access is swallowed while the slave is still waiting for the two zeros. Long runs of ones, resets started in the middle of an access, and back-to-back patterns are aimed at exactly these faults.

// File: rtl/twsl_pkg.sv
package twsl_pkg;
  localparam int BLK_W     = 5;
  localparam int BOOST_BIT = 5;
  localparam int TEST_LSB  = 6;
  localparam int TEST_W    = 2;

  localparam logic [7:0] GAIN_POR = 8'h00;
  localparam logic [7:0] CTL_POR  = 8'h10;
  localparam logic       AGC_POR  = 1'b0;

  typedef enum logic {
    FR_ACCESS = 1'b0,
    FR_HUNT   = 1'b1
  } frm_state_e;
endpackage

// File: rtl/twsl_sync.sv
module twsl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sdata_in,
  output logic sclk_rise,
  output logic bit_val
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] dt_q;
  logic              ck_prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ck_q[g] <= 1'b0;
            dt_q[g] <= 1'b0;
          end else begin
            ck_q[g] <= sclk;
            dt_q[g] <= sdata_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ck_q[g] <= 1'b0;
            dt_q[g] <= 1'b0;
          end else begin
            ck_q[g] <= ck_q[g-1];
            dt_q[g] <= dt_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_prev_q <= 1'b0;
    else        ck_prev_q <= ck_q[STAGES-1];
  end

  assign sclk_rise = ck_q[STAGES-1] & ~ck_prev_q;
  assign bit_val   = dt_q[STAGES-1];
endmodule

// File: rtl/twsl_framer.sv
module twsl_framer
  import twsl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int RST_ONES  = 16,
  parameter int RST_ZEROS = 2,
  parameter int IDX_W     = $clog2(ADDR_W + DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              bit_val,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_load,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              bit_adv,
  output logic              frame_end,
  output logic              abort,
  output logic              rst_stb,
  output logic              hunting,
  output logic [IDX_W-1:0]  bit_idx
);
  localparam int FRAME_LEN = ADDR_W + 1 + DATA_W;
  localparam int SH_W      = FRAME_LEN - 1;
  localparam int ONES_W    = $clog2(RST_ONES + 1);
  localparam int ZC_W      = $clog2(RST_ZEROS + 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0]  RW_IDX   = IDX_W'(ADDR_W);
  localparam logic [ONES_W-1:0] ONES_LIM = ONES_W'(RST_ONES - 1);
  localparam logic [ZC_W-1:0]   ZC_LIM   = ZC_W'(RST_ZEROS - 1);

  frm_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic [ZC_W-1:0]   zc_q, zc_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic [FRAME_LEN-1:0] word;

  assign word = {sh_q, bit_val};

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    ones_d    = ones_q;
    zc_d      = zc_q;
    sh_d      = sh_q;
    wr_stb    = 1'b0;
    rd_load   = 1'b0;
    bit_adv   = 1'b0;
    frame_end = 1'b0;
    abort     = 1'b0;
    rst_stb   = 1'b0;
    if (bit_rise) begin
      unique case (st_q)
        FR_ACCESS: begin
          ones_d = bit_val ? ones_q + ONES_W'(1) : '0;
          if (bit_val && (ones_q == ONES_LIM)) begin
            st_d  = FR_HUNT;
            idx_d = '0;
            zc_d  = '0;
            abort = 1'b1;
          end else begin
            bit_adv = 1'b1;
            sh_d    = {sh_q[SH_W-2:0], bit_val};
            if (idx_q == LAST_IDX) begin
              idx_d     = '0;
              frame_end = 1'b1;
              wr_stb    = ~word[DATA_W];
            end else begin
              idx_d   = idx_q + IDX_W'(1);
              rd_load = (idx_q == RW_IDX) & bit_val;
            end
          end
        end
        FR_HUNT: begin
          if (!bit_val) begin
            if (zc_q == ZC_LIM) begin
              rst_stb = 1'b1;
              st_d    = FR_ACCESS;
              ones_d  = '0;
              zc_d    = '0;
            end else begin
              zc_d = zc_q + ZC_W'(1);
            end
          end else if (zc_q != '0) begin
            st_d   = FR_ACCESS;
            ones_d = ONES_W'(1);
            zc_d   = '0;
          end
        end
        default: st_d = FR_ACCESS;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_ACCESS;
      idx_q  <= '0;
      ones_q <= '0;
      zc_q   <= '0;
      sh_q   <= '0;
    end else if (bit_rise) begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      ones_q <= ones_d;
      zc_q   <= zc_d;
      sh_q   <= sh_d;
    end
  end

  assign wr_addr = word[FRAME_LEN-1 -: ADDR_W];
  assign wr_data = word[DATA_W-1:0];
  assign rd_addr = sh_q[ADDR_W-1:0];
  assign hunting = (st_q == FR_HUNT);
  assign bit_idx = idx_q;
endmodule

// File: rtl/twsl_regbank.sv
module twsl_regbank
  import twsl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rst_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] gain_code,
  output logic [BLK_W-1:0]  black_code,
  output logic              boost_sel,
  output logic [TEST_W-1:0] test_mode,
  output logic              agc_en
);
  localparam logic [ADDR_W-1:0] A_GAIN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_AGC  = ADDR_W'(2);

  logic [DATA_W-1:0] gain_q, gain_d;
  logic [DATA_W-1:0] ctl_q, ctl_d;
  logic              agc_q, agc_d;
  logic              upd;

  assign upd = wr_stb | rst_stb;

  always_comb begin
    gain_d = gain_q;
    ctl_d  = ctl_q;
    agc_d  = agc_q;
    if (rst_stb) begin
      gain_d = DATA_W'(GAIN_POR);
      ctl_d  = DATA_W'(CTL_POR);
      agc_d  = AGC_POR;
    end else if (wr_stb) begin
      if (wr_addr == A_GAIN) gain_d = wr_data;
      if (wr_addr == A_CTL)  ctl_d  = wr_data;
      if (wr_addr == A_AGC)  agc_d  = wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= DATA_W'(GAIN_POR);
      ctl_q  <= DATA_W'(CTL_POR);
      agc_q  <= AGC_POR;
    end else if (upd) begin
      gain_q <= gain_d;
      ctl_q  <= ctl_d;
      agc_q  <= agc_d;
    end
  end

  always_comb begin
    if (rd_addr == A_GAIN)      rd_data = gain_q;
    else if (rd_addr == A_CTL)  rd_data = ctl_q;
    else if (rd_addr == A_AGC)  rd_data = {{(DATA_W-1){1'b0}}, agc_q};
    else                        rd_data = '0;
  end

  assign gain_code  = gain_q;
  assign black_code = ctl_q[BLK_W-1:0];
  assign boost_sel  = ctl_q[BOOST_BIT];
  assign test_mode  = ctl_q[TEST_LSB +: TEST_W];
  assign agc_en     = agc_q;
endmodule

// File: rtl/twsl_readout.sv
module twsl_readout #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              bit_adv,
  input  logic              frame_end,
  input  logic              abort,
  output logic              sdata_out,
  output logic              sdata_oe
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              upd;

  always_comb begin
    sh_d = sh_q;
    oe_d = oe_q;
    if (abort || frame_end) begin
      oe_d = 1'b0;
      sh_d = '0;
    end else if (rd_load) begin
      oe_d = 1'b1;
      sh_d = rd_data;
    end else if (bit_adv && oe_q) begin
      sh_d = {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign upd = abort | frame_end | rd_load | bit_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (upd) begin
      sh_q <= sh_d;
      oe_q <= oe_d;
    end
  end

  assign sdata_oe  = oe_q;
  assign sdata_out = oe_q & sh_q[DATA_W-1];
endmodule

// File: rtl/twsl_ctrl.sv
module twsl_ctrl
  import twsl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int RST_ONES    = 16,
  parameter int RST_ZEROS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic [DATA_W-1:0] gain_code,
  output logic [BLK_W-1:0]  black_code,
  output logic              boost_sel,
  output logic [TEST_W-1:0] test_mode,
  output logic              agc_en
);
  localparam int FRAME_LEN = ADDR_W + 1 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  logic              sclk_rise;
  logic              bit_val;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              rd_load;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              bit_adv;
  logic              frame_end;
  logic              abort;
  logic              rst_stb;
  logic              hunting;
  logic [IDX_W-1:0]  bit_idx;

  twsl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .sdata_in (sdata_in),
    .sclk_rise(sclk_rise),
    .bit_val  (bit_val)
  );

  twsl_framer #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RST_ONES (RST_ONES),
    .RST_ZEROS(RST_ZEROS),
    .IDX_W    (IDX_W)
  ) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_rise (sclk_rise),
    .bit_val  (bit_val),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_load  (rd_load),
    .rd_addr  (rd_addr),
    .bit_adv  (bit_adv),
    .frame_end(frame_end),
    .abort    (abort),
    .rst_stb  (rst_stb),
    .hunting  (hunting),
    .bit_idx  (bit_idx)
  );

  twsl_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rst_stb   (rst_stb),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .gain_code (gain_code),
    .black_code(black_code),
    .boost_sel (boost_sel),
    .test_mode (test_mode),
    .agc_en    (agc_en)
  );

  twsl_readout #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_load  (rd_load),
    .rd_data  (rd_data),
    .bit_adv  (bit_adv),
    .frame_end(frame_end),
    .abort    (abort),
    .sdata_out(sdata_out),
    .sdata_oe (sdata_oe)
  );
endmodule

// File: rtl/twsl_ctrl_chk.sv
module twsl_ctrl_chk #(
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 4,
  parameter int FRAME_LEN = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdata_out,
  input logic              sdata_oe,
  input logic [DATA_W-1:0] gain_code,
  input logic [4:0]        black_code,
  input logic              boost_sel,
  input logic [1:0]        test_mode,
  input logic              agc_en,
  input logic              sclk_rise,
  input logic              hunting,
  input logic [IDX_W-1:0]  bit_idx
);
  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx < IDX_W'(FRAME_LEN));

  // R5
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe != $past(sdata_oe)) |-> $past(sclk_rise));

  // R5
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata_out);

  // R3 R4 R6
  regs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable({gain_code, black_code, boost_sel, test_mode, agc_en}));

  // R7
  hunt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunting |-> !sdata_oe);

  // R9
  hunt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting && !sclk_rise) |=> hunting);
endmodule

bind twsl_ctrl twsl_ctrl_chk #(
  .DATA_W   (DATA_W),
  .IDX_W    (IDX_W),
  .FRAME_LEN(FRAME_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sdata_out (sdata_out),
  .sdata_oe  (sdata_oe),
  .gain_code (gain_code),
  .black_code(black_code),
  .boost_sel (boost_sel),
  .test_mode (test_mode),
  .agc_en    (agc_en),
  .sclk_rise (sclk_rise),
  .hunting   (hunting),
  .bit_idx   (bit_idx)
);

// File: tb/twsl_ctrl_test.sv
`timescale 1ns/1ps
module twsl_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sclk;
  logic       sdata_in;
  logic       sdata_out;
  logic       sdata_oe;
  logic [7:0] gain_code;
  logic [4:0] black_code;
  logic       boost_sel;
  logic [1:0] test_mode;
  logic       agc_en;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [7:0] m_gain, m_ctl;
  logic       m_agc;

  always #10 clk = ~clk;

  twsl_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .gain_code(gain_code),
    .black_code(black_code), .boost_sel(boost_sel), .test_mode(test_mode),
    .agc_en(agc_en)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0:    exp_rd = m_gain;
      4'd1:    exp_rd = m_ctl;
      4'd2:    exp_rd = {7'd0, m_agc};
      default: exp_rd = 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0:    tag_of = "R2";
      4'd1:    tag_of = "R3";
      4'd2:    tag_of = "R4";
      default: tag_of = "R6";
    endcase
  endfunction

  task automatic set_por();
    m_gain = 8'h00; m_ctl = 8'h10; m_agc = 1'b0;
  endtask

  task automatic chk_outs(input string tag);
    chk(tag, "gain_code",  int'(gain_code),  int'(m_gain));
    chk(tag, "black_code", int'(black_code), int'(m_ctl[4:0]));
    chk(tag, "boost_sel",  int'(boost_sel),  int'(m_ctl[5]));
    chk(tag, "test_mode",  int'(test_mode),  int'(m_ctl[7:6]));
    chk(tag, "agc_en",     int'(agc_en),     int'(m_agc));
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sdata_in = b;
    repeat (6) @(negedge clk);
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    for (int i = 3; i >= 0; i--) send_bit(a[i]);
    send_bit(1'b0);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    if (a == 4'd0) m_gain = d;
    if (a == 4'd1) m_ctl = d;
    if (a == 4'd2) m_agc = d[0];
    repeat (2) @(negedge clk);
    chk_outs(tag_of(a));
  endtask

  task automatic do_read(input logic [3:0] a);
    logic [7:0] got;
    got = 8'h00;
    for (int i = 3; i >= 0; i--) send_bit(a[i]);
    send_bit(1'b1);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sdata_in = 1'b0;
      repeat (6) @(negedge clk);
      chk("R5", "sdata_oe during data", int'(sdata_oe), 1);
      got[i] = sdata_out;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
    chk(tag_of(a), "read data", int'(got), int'(exp_rd(a)));
    repeat (2) @(negedge clk);
    chk("R5", "sdata_oe after 13th edge", int'(sdata_oe), 0);
  endtask

  task automatic reset_pattern(input int extra_ones);
    for (int i = 0; i < 16 + extra_ones; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b0);
    set_por();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0;
    sclk = 1'b0;
    sdata_in = 1'b0;
    set_por();
    repeat (5) @(negedge clk);
    chk_outs("R1");
    chk("R1", "sdata_oe in reset", int'(sdata_oe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_outs("R1");
    chk("R1", "sdata_oe after reset", int'(sdata_oe), 0);

    // R2 R3 R4: field writes
    do_write(4'd0, 8'hA5);
    do_write(4'd1, 8'hEB);
    do_write(4'd1, 8'h8A);
    do_write(4'd2, 8'hFF);
    do_read(4'd2);
    // R5: read timing with nonzero patterns
    do_read(4'd0);
    do_read(4'd1);
    // R6: unimplemented addresses
    do_write(4'd5, 8'h77);
    do_write(4'd15, 8'h00);
    do_read(4'd7);
    do_read(4'd15);

    // R7: reset pattern starting inside an access
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    reset_pattern(0);
    repeat (2) @(negedge clk);
    chk_outs("R7");
    chk("R7", "sdata_oe after reset pattern", int'(sdata_oe), 0);

    // R8: back-to-back patterns, no idle
    do_write(4'd0, 8'h3C);
    reset_pattern(0);
    do_write(4'd1, 8'h5F);
    chk("R8", "gain after back-to-back reset", int'(gain_code), 0);
    chk("R8", "black after back-to-back write", int'(black_code), 5'h1F);

    // R9: long run of ones, then re-armed framer
    do_write(4'd2, 8'h01);
    reset_pattern(7);
    repeat (2) @(negedge clk);
    chk_outs("R9");
    do_write(4'd0, 8'h81);
    chk("R9", "gain after long reset run", int'(gain_code), 8'h81);

    // Random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 120; n++) begin
      logic [3:0] a;
      r = $urandom();
      a = (r[7:5] == 3'd0) ? r[11:8] : 4'(r[13:12] % 3);
      if (r[19:16] == 4'd0) begin
        reset_pattern(int'(r[22:20]));
        repeat (2) @(negedge clk);
        chk_outs("R7");
      end else if (r[2:0] < 3'd5) begin
        do_write(a, r[31:24]);
      end else begin
        do_read(a);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule